// File: doc/BRIEF.md
# Low-Transition Scan Pattern Source

This block supplies the serial stimulus for one scan chain during built-in self-test. A 16-bit maximal-length shift register produces pseudo-random state. The scan bit is not taken straight from that register. A small AND of selected register bits drives the toggle input of a single toggle flip-flop, and that flip-flop's output is the bit shifted into the chain. The scan bit therefore flips only when every selected bit is 1. With more AND inputs this happens less often, so neighbouring scan bits agree far more often than with raw pseudo-random data, and the chain sees fewer transitions while it shifts.

A test controller loads a seed, then raises the shift enable for as many cycles as it needs. The seed changes how much the pattern switches, so it is a tuning input. An all-zero seed would lock the register up, so the block swaps in a fixed nonzero constant instead. A position counter runs alongside the shifting. It reports which bit of the current vector is being shifted and pulses once each time a full chain load completes.

Top module: `lowtx_scan_tpg`

## Requirements
- R1: While reset (active low) is asserted, and on the first edge after it is released with no other input active, scan_bit, bit_idx and vec_done are all 0.
- R2: The generator state s[15:0] advances on each shift cycle as a left shift, with new s[0] = s[15] ^ s[13] ^ s[12] ^ s[10].
- R3: On a shift cycle, scan_bit inverts when the AND of the first AND_K bits in the list s[0], s[4], s[8], s[12] is 1, evaluated on the state before that shift; otherwise scan_bit keeps its value.
- R4: On a cycle with shift_en and seed_load both low, scan_bit, bit_idx and the generator state all hold, so shifting later resumes the same sequence.
- R5: seed_load loads the state from seed_in, clears scan_bit to 0 and clears bit_idx to 0. It takes priority over shift_en in the same cycle.
- R6: Loading a seed of 0 loads SAFE_SEED (default 16'hACE1) instead, so the state never becomes all-zero.
- R7: bit_idx increments by one on each shift cycle and wraps from CHAIN_LEN-1 to 0.
- R8: vec_done is high for exactly one cycle after the shift that wraps bit_idx to 0, and is low at all other times.
- R9: After reset, the generator state is SAFE_SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load strobe for seed_in |
| seed_in | input | 16 | Seed value for the generator state |
| shift_en | input | 1 | Advances the state, the toggle flip-flop and the counter |
| scan_bit | output | 1 | Serial scan-in value (toggle flip-flop output) |
| bit_idx | output | IDX_W | Position of the current bit in the vector |
| vec_done | output | 1 | One-cycle pulse after each full chain load |

## Verification
The generator state is not brought out directly. A corrupted state or a wrong feedback tap shows up at scan_bit as a wrong toggle or a missed toggle. With two AND inputs, a toggle is due about once every four shifts, so a divergence appears within a few shift cycles of the fault. Errors in the counter or in the pulse are visible on bit_idx or vec_done on the very next edge. An idle cycle that disturbs the state appears later, once shifting resumes, as a scan stream that departs from the expected one.

// File: rtl/lowtx_scan_tpg.sv
module lowtx_scan_tpg #(
  parameter int          AND_K     = 2,
  parameter int          CHAIN_LEN = 8,
  parameter logic [15:0] SAFE_SEED = 16'hACE1,
  localparam int         IDX_W     = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [15:0]      seed_in,
  input  logic             shift_en,
  output logic             scan_bit,
  output logic [IDX_W-1:0] bit_idx,
  output logic             vec_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);

  logic [15:0] lfsr;
  logic        fb;
  logic        and_hit;
  logic        tff;
  logic [IDX_W-1:0] idx;
  logic        done_q;

  assign fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_comb begin
    and_hit = 1'b1;
    for (int i = 0; i < AND_K; i++) and_hit = and_hit & lfsr[4*i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr   <= SAFE_SEED;
      tff    <= 1'b0;
      idx    <= '0;
      done_q <= 1'b0;
    end else if (seed_load) begin
      lfsr   <= (seed_in == 16'h0000) ? SAFE_SEED : seed_in;
      tff    <= 1'b0;
      idx    <= '0;
      done_q <= 1'b0;
    end else if (shift_en) begin
      lfsr   <= {lfsr[14:0], fb};
      tff    <= tff ^ and_hit;
      idx    <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      done_q <= (idx == LAST_IDX);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign scan_bit = tff;
  assign bit_idx  = idx;
  assign vec_done = done_q;

endmodule

// File: rtl/lowtx_scan_tpg_chk.sv
module lowtx_scan_tpg_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int IDX_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seed_load,
  input logic             shift_en,
  input logic             and_hit,
  input logic [15:0]      lfsr,
  input logic             scan_bit,
  input logic [IDX_W-1:0] bit_idx,
  input logic             vec_done
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !seed_load) |=> ($stable(scan_bit) && $stable(bit_idx) && $stable(lfsr))); // R4

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (!scan_bit && bit_idx == '0)); // R5

  AST_NO_SPURIOUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !seed_load && !and_hit) |=> $stable(scan_bit)); // R3

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000); // R6

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_idx) < CHAIN_LEN); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_done && !shift_en) |=> !vec_done); // R8

endmodule

bind lowtx_scan_tpg lowtx_scan_tpg_chk #(.CHAIN_LEN(CHAIN_LEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .shift_en(shift_en),
  .and_hit(and_hit), .lfsr(lfsr), .scan_bit(scan_bit), .bit_idx(bit_idx),
  .vec_done(vec_done)
);

// File: tb/lowtx_scan_tpg_bench.sv
module lowtx_scan_tpg_bench;
  localparam int          K    = 2;
  localparam int          LEN  = 8;
  localparam logic [15:0] SAFE = 16'hACE1;
  localparam int          IW   = $clog2(LEN);

  logic clk = 0, rst_n = 0, seed_load = 0, shift_en = 0;
  logic [15:0] seed_in = '0;
  logic scan_bit, vec_done;
  logic [IW-1:0] bit_idx;

  int checks = 0, errors = 0;
  logic [15:0] m_lfsr;
  logic m_tff, m_done;
  int m_idx;

  always #10 clk = ~clk;

  lowtx_scan_tpg #(.AND_K(K), .CHAIN_LEN(LEN), .SAFE_SEED(SAFE)) u_lowtx_scan_tpg (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
    .shift_en(shift_en), .scan_bit(scan_bit), .bit_idx(bit_idx), .vec_done(vec_done));

  // {seed, shifts, idle gap every n shifts (0 = none)}
  localparam logic [31:0] VECS [6] = '{
    {16'h1234, 8'd40, 8'd0},
    {16'h0000, 8'd40, 8'd0},
    {16'hFFFF, 8'd30, 8'd3},
    {16'h8001, 8'd24, 8'd5},
    {16'hACE1, 8'd20, 8'd0},
    {16'h5A5A, 8'd33, 8'd7}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic ld, logic [15:0] sd, logic sh, string tag);
    logic hit;
    @(negedge clk);
    seed_load = ld; seed_in = sd; shift_en = sh;
    @(posedge clk);
    if (ld) begin
      m_lfsr = (sd == 16'h0) ? SAFE : sd;  // R6
      m_tff = 0; m_idx = 0; m_done = 0;
    end else if (sh) begin
      hit = 1'b1;
      for (int i = 0; i < K; i++) hit &= m_lfsr[4*i];
      m_tff ^= hit;
      m_done = (m_idx == LEN-1);
      m_idx = (m_idx == LEN-1) ? 0 : m_idx + 1;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15]^m_lfsr[13]^m_lfsr[12]^m_lfsr[10]};
    end else m_done = 0;
    @(negedge clk);
    seed_load = 0; shift_en = 0;
    chk(tag, scan_bit, m_tff);
    chk("R7 bit_idx", bit_idx, m_idx);
    chk("R8 vec_done", vec_done, m_done);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 scan_bit in reset", scan_bit, 0);
    chk("R1 bit_idx in reset", bit_idx, 0);
    chk("R1 vec_done in reset", vec_done, 0);
    rst_n = 1;
    m_lfsr = SAFE; m_tff = 0; m_idx = 0; m_done = 0;
    step(0, 16'h0, 0, "R1 idle after reset");
    for (int n = 0; n < 20; n++) step(0, 16'h0, 1, "R9 R2 R3 reset seed stream");

    foreach (VECS[v]) begin
      step(1, VECS[v][31:16], 0, "R5 load");
      for (int n = 0; n < int'(VECS[v][15:8]); n++) begin
        step(0, 16'h0, 1, (VECS[v][31:16] == 0) ? "R6 zero seed stream" : "R2 R3 stream");
        if (VECS[v][7:0] != 0 && (n % int'(VECS[v][7:0])) == 0)
          step(0, 16'h0, 0, "R4 idle hold");
      end
    end

    // R5: load wins over shift in the same cycle, mid-vector
    for (int n = 0; n < 5; n++) step(0, 16'h0, 1, "R3 pre-load");
    step(1, 16'h0F0F, 1, "R5 load priority");
    for (int n = 0; n < 10; n++) step(0, 16'h0, 1, "R2 R3 after priority load");

    // R4: long idle then resume
    for (int n = 0; n < 6; n++) step(0, 16'h0, 0, "R4 long idle");
    for (int n = 0; n < 12; n++) step(0, 16'h0, 1, "R4 resume stream");

    // R8: vec_done pulse followed by idle must fall
    while (m_idx != LEN-1) step(0, 16'h0, 1, "R7 advance");
    step(0, 16'h0, 1, "R8 wrap shift");
    chk("R8 pulse present", vec_done, 1);
    step(0, 16'h0, 0, "R8 idle after pulse");
    chk("R8 pulse cleared", vec_done, 0);

    // R1: mid-run reset
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 scan_bit mid reset", scan_bit, 0);
    chk("R1 bit_idx mid reset", bit_idx, 0);
    rst_n = 1;
    m_lfsr = SAFE; m_tff = 0; m_idx = 0; m_done = 0;
    for (int n = 0; n < 16; n++) step(0, 16'h0, 1, "R9 stream after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule